// File: doc/BRIEF.md
# System tick down-counter timer

This block is a periodic timer that counts processor clocks downward in a 24-bit register. Software programs a reload value, sets the enable bit, and the counter decrements once per clock until it reaches zero. On the following clock it loads the reload value again. When it reaches zero, a sticky flag is set. If interrupt generation is enabled, the block also sends a one-clock tick request to the exception controller.

Software reaches the block through a simple word bus. Each access has a valid strobe, a write strobe, a 2-bit word address and 32-bit data. Reads return the register state at the moment of the access. Reading the control word clears the sticky flag, and writing the current-value word clears both the counter and the flag. A halt input freezes the count, which covers both a debug halt and a stopped clock.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the enable bit, the interrupt-enable bit, the flag, the reload register and the counter are all zero, and tick_req is low.
- R2: While enabled and not halted, a non-zero counter decreases by one on every clock. A read of word address 2 returns the live counter value at the time of the access.
- R3: While enabled and not halted, a counter at zero loads the reload register value on the next clock.
- R4: When the reload register holds zero, the counter stays at zero after the wrap and stops decrementing.
- R5: The flag, read at bit 16 of word address 0, is set on the clock where the counter moves from 1 to 0. It stays set until it is cleared.
- R6: Any read of word address 0 clears the flag. If such a read falls on the same clock as a move from 1 to 0, the flag ends up set.
- R7: A write of any value to word address 2 sets the counter to zero and clears the flag. The write never causes a tick request.
- R8: tick_req is high for exactly one clock after each move from 1 to 0, and only if the interrupt-enable bit is set.
- R9: While halt is high, the counter and the flag keep their values. The only exceptions are a bus write to the counter and a flag-clearing read.
- R10: The reload register (word address 1) and the counter are 24 bits wide. Bits 31:24 read as zero, and writes to those bits are ignored.
- R11: Word address 0 holds enable at bit 0 and interrupt-enable at bit 1. These bits are written by a write to that address and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Freezes counting while high |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control, 1 reload, 2 current |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| tick_req | output | 1 | One-clock tick request to the exception controller |

## Verification
Read data has no register stage: the bench compares it in the same cycle as the request, against model state from before the next edge. Counter, reload and control updates caused by a bus access, or by the count itself, become visible one clock edge later. The bench therefore steps its model exactly once per rising edge, and compares reads and tick_req half a period after that edge. tick_req comes from a register and rises in the cycle after the edge on which the counter reaches zero, which is the same cycle in which the counter first reads as zero. Directed sequences place a control read on the exact zero-reach edge and write the counter during a halt. Random traffic with short reload values covers many wraps.

// File: rtl/sys_tick_pkg.sv
package sys_tick_pkg;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_RELOAD  = 2'd1,
        REG_CURRENT = 2'd2,
        REG_SPARE   = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_FLAG_BIT = 16;

endpackage

// File: rtl/stt_down_count.sv
module stt_down_count #(
    parameter int CNT_W = 24
) (
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] nxt,
    output logic             reach_zero
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    always_comb begin
        nxt        = cur;
        reach_zero = 1'b0;
        if (clear) begin
            nxt = ZERO;
        end else if (run) begin
            if (cur == ZERO) begin
                nxt = reload;
            end else begin
                nxt        = cur - ONE;
                reach_zero = (cur == ONE);
            end
        end
    end

endmodule

// File: rtl/stt_bus_decode.sv
module stt_bus_decode
    import sys_tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              valid,
    input  logic              write,
    input  logic [1:0]        addr,
    input  logic              en,
    input  logic              ie,
    input  logic              flag,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  cur,
    output logic              wr_ctrl,
    output logic              wr_reload,
    output logic              wr_cur,
    output logic              rd_ctrl,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - CNT_W;

    logic [DATA_W-1:0] reload_ext;
    logic [DATA_W-1:0] cur_ext;
    logic [DATA_W-1:0] ctrl_word;
    reg_sel_e          sel;

    generate
        if (PAD_W > 0) begin : g_pad
            assign reload_ext = {{PAD_W{1'b0}}, reload};
            assign cur_ext    = {{PAD_W{1'b0}}, cur};
        end else begin : g_nopad
            assign reload_ext = reload[DATA_W-1:0];
            assign cur_ext    = cur[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[CTRL_EN_BIT]   = en;
        ctrl_word[CTRL_IE_BIT]   = ie;
        ctrl_word[CTRL_FLAG_BIT] = flag;
    end

    assign sel       = reg_sel_e'(addr);
    assign wr_ctrl   = valid &&  write && (sel == REG_CTRL);
    assign wr_reload = valid &&  write && (sel == REG_RELOAD);
    assign wr_cur    = valid &&  write && (sel == REG_CURRENT);
    assign rd_ctrl   = valid && !write && (sel == REG_CTRL);

    always_comb begin
        rdata = '0;
        if (valid && !write) begin
            unique case (sel)
                REG_CTRL:    rdata = ctrl_word;
                REG_RELOAD:  rdata = reload_ext;
                REG_CURRENT: rdata = cur_ext;
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
    import sys_tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_req
);

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             flag;
        logic             tick;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cur;
    } tick_state_t;

    tick_state_t      st_d, st_q;
    logic             wr_ctrl, wr_reload, wr_cur, rd_ctrl;
    logic             run;
    logic             reach_zero;
    logic [CNT_W-1:0] cnt_nxt;

    stt_bus_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dec_i (
        .valid     (bus_valid),
        .write     (bus_write),
        .addr      (bus_addr),
        .en        (st_q.en),
        .ie        (st_q.ie),
        .flag      (st_q.flag),
        .reload    (st_q.reload),
        .cur       (st_q.cur),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .wr_cur    (wr_cur),
        .rd_ctrl   (rd_ctrl),
        .rdata     (bus_rdata)
    );

    assign run = st_q.en && !halt;

    stt_down_count #(.CNT_W(CNT_W)) cnt_i (
        .run        (run),
        .clear      (wr_cur),
        .cur        (st_q.cur),
        .reload     (st_q.reload),
        .nxt        (cnt_nxt),
        .reach_zero (reach_zero)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.cur  = cnt_nxt;
        if (wr_ctrl) begin
            st_d.en = bus_wdata[CTRL_EN_BIT];
            st_d.ie = bus_wdata[CTRL_IE_BIT];
        end
        if (wr_reload) begin
            st_d.reload = bus_wdata[CNT_W-1:0];
        end
        if (rd_ctrl) begin
            st_d.flag = 1'b0;
        end
        if (wr_cur) begin
            st_d.flag = 1'b0;
        end else if (reach_zero) begin
            st_d.flag = 1'b1;
            st_d.tick = st_q.ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_req = st_q.tick;

endmodule

// File: rtl/stt_checker.sv
module stt_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_req,
    input logic              en_q,
    input logic              ie_q,
    input logic              flag_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  cur_q
);

    logic cur_wr;
    logic ctrl_rd;
    logic word_rd;
    assign cur_wr  = bus_valid && bus_write && (bus_addr == 2'd2);
    assign ctrl_rd = bus_valid && !bus_write && (bus_addr == 2'd0);
    assign word_rd = bus_valid && !bus_write && (bus_addr != 2'd0);

    assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_req |=> !tick_req);

    assert_tick_needs_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_req |-> $past(ie_q));

    assert_tick_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_req |-> (flag_q && cur_q == '0));

    assert_cur_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cur_q == '0 && !flag_q && !tick_req));

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !cur_wr) |=> $stable(cur_q));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !cur_wr && !ctrl_rd) |=> $stable(flag_q));

    assert_wrap_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !halt && !cur_wr && cur_q == '0) |=> (cur_q == $past(reload_q)));

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        word_rd |-> (bus_rdata[DATA_W-1:CNT_W] == '0));

endmodule

bind sys_tick_timer stt_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .tick_req  (tick_req),
    .en_q      (st_q.en),
    .ie_q      (st_q.ie),
    .flag_q    (st_q.flag),
    .reload_q  (st_q.reload),
    .cur_q     (st_q.cur)
);

// File: tb/sys_tick_timer_tb_top.sv
`timescale 1ns/1ps
module sys_tick_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        tick_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [23:0] m_cur, m_rel;
    logic        m_en, m_ie, m_flag, m_tick;

    always #2 clk = ~clk;

    sys_tick_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_req  (tick_req)
    );

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {15'd0, m_flag, 14'd0, m_ie, m_en};
            2'd1:    return {8'd0, m_rel};
            2'd2:    return {8'd0, m_cur};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_step(input logic v, input logic w, input logic [1:0] a,
                                       input logic [31:0] d, input logic h);
        logic [23:0] n_cur  = m_cur;
        logic [23:0] n_rel  = m_rel;
        logic        n_en   = m_en;
        logic        n_ie   = m_ie;
        logic        n_flag = m_flag;
        logic        n_tick = 1'b0;
        if (v && w && a == 2'd0) begin n_en = d[0]; n_ie = d[1]; end
        if (v && w && a == 2'd1) n_rel = d[23:0];
        if (v && !w && a == 2'd0) n_flag = 1'b0;
        if (v && w && a == 2'd2) begin
            n_cur = 24'd0; n_flag = 1'b0;
        end else if (m_en && !h) begin
            if (m_cur == 24'd0) n_cur = m_rel;
            else begin
                n_cur = m_cur - 24'd1;
                if (m_cur == 24'd1) begin n_flag = 1'b1; n_tick = m_ie; end
            end
        end
        m_cur = n_cur; m_rel = n_rel; m_en = n_en; m_ie = n_ie;
        m_flag = n_flag; m_tick = n_tick;
    endfunction

    task automatic cyc(input logic v, input logic w, input logic [1:0] a,
                       input logic [31:0] d, input logic h, input string tag);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; halt = h;
        #0.5;
        chk("R8 tick_req", {31'd0, tick_req}, {31'd0, m_tick});
        if (v && !w) chk(tag, bus_rdata, exp_read(a));
        @(posedge clk);
        model_step(v, w, a, d, h);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 32'd0, 1'b0, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d, 1'b0, "wr");
    endtask

    task automatic idle(input logic h);
        cyc(1'b0, 1'b0, 2'd0, 32'd0, h, "idle");
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cur = '0; m_rel = '0; m_en = 0; m_ie = 0; m_flag = 0; m_tick = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 tick_req", {31'd0, tick_req}, 32'd0);
        rd(2'd0, "R1 ctrl");
        rd(2'd1, "R1 reload");
        rd(2'd2, "R1 current");

        // R10 upper bits ignored
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, "R10 reload upper");
        wr(2'd1, 32'hAB00_0003);
        rd(2'd1, "R10 reload masked");

        // R11 control bits, R2/R3 count and wrap with interrupts
        wr(2'd0, 32'hFFFF_FFFC);
        rd(2'd0, "R11 ctrl masked");
        wr(2'd0, 32'h0000_0003);
        rd(2'd0, "R11 ctrl set");
        for (int i = 0; i < 12; i++) rd(2'd2, "R2 R3 current");

        // R6 flag clear on read; read coinciding with zero reach
        for (int i = 0; i < 10; i++) rd(2'd0, "R5 R6 ctrl flag");

        // R9 halt freezes counting
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 2'd2, 32'd0, 1'b1, "R9 halted current");
        // R7 write to current during run and halt
        cyc(1'b1, 1'b1, 2'd2, 32'h1234_5678, 1'b1, "R7");
        rd(2'd2, "R7 current zero");
        rd(2'd0, "R7 flag clear");
        idle(1'b0); idle(1'b0);
        wr(2'd2, 32'd5);
        rd(2'd2, "R7 current cleared");

        // R8 no tick with interrupt disabled
        wr(2'd0, 32'h0000_0001);
        for (int i = 0; i < 10; i++) idle(1'b0);
        rd(2'd0, "R8 flag without tick");

        // R4 zero reload stops counter
        wr(2'd1, 32'd0);
        for (int i = 0; i < 8; i++) rd(2'd2, "R4 current stopped");

        // Random traffic
        wr(2'd0, 32'h3);
        for (int i = 0; i < 3000; i++) begin
            int op = int'($urandom % 10);
            logic h = ($urandom % 8) == 0;
            case (op)
                0, 1, 2: idle(h);
                3: cyc(1'b1, 1'b0, 2'd0, 32'd0, h, "R6 rand ctrl");
                4, 5: cyc(1'b1, 1'b0, 2'd2, 32'd0, h, "R2 rand current");
                6: cyc(1'b1, 1'b0, 2'd1, 32'd0, h, "R10 rand reload");
                7: cyc(1'b1, 1'b1, 2'd1, {$urandom} & 32'hFF00_0007, h, "w");
                8: if (($urandom % 4) == 0) cyc(1'b1, 1'b1, 2'd2, $urandom, h, "w");
                   else idle(h);
                default: cyc(1'b1, 1'b1, 2'd0, ($urandom % 8) == 0 ? 32'd2 : 32'd3, h, "w");
            endcase
        end

        idle(1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule